// File: doc/BRIEF.md
# Read Burst Inversion and CRC Framer

This block forms the read burst for one or more byte lanes of a DRAM-style data port and checks the CRC on incoming write bursts. For a read, the block takes all eight data bytes of a lane at once. For each beat it decides whether to send the byte inverted, and it reports that choice on a per-lane flag line. It then computes an 8-bit CRC over the 72 bits that actually travel on the lane: eight beats of eight data bits plus the flag bit. With CRC enabled, that checksum goes out as a ninth beat. Because inversion happens first, the CRC always protects the wire values. Each byte lane owns its own inversion logic and its own CRC, so a two-lane configuration runs two independent checksums rather than one wide one.

On the write side, the block receives beats exactly as they arrive on the wire, with no inversion undone. It accumulates the same CRC per lane and compares it with the ninth beat. A mismatch latches a per-lane error flag, which stays set until software pulses a clear. Two mode inputs enable inversion and CRC independently. The read modes are sampled when a read burst is launched.

Top module: `rd_dbi_crc_framer`

## Requirements
- R1: After reset, tx_valid and tx_last are low, tx_dq is all zeros, tx_dbi_n is all ones and crc_err is all zeros; whenever tx_valid is low, tx_dq is zero and tx_dbi_n is all ones.
- R2: With inversion enabled, a data byte holding more than four zero bits is sent bit-inverted with its lane flag low; a byte with four or fewer zeros is sent unchanged with the flag high.
- R3: With inversion disabled, every data byte is sent unchanged and the lane flag stays high on every beat.
- R4: A rd_start pulse seen while tx_valid is low starts a burst: beat b (b = 0..7), holding source byte rd_data[l*64+8b +: 8] for lane l, is on tx_dq in the (b+1)-th cycle after that edge, and the beats run with no gaps.
- R5: With CRC enabled, the burst has a ninth beat. On that beat each lane carries its CRC on tx_dq, its flag is high, and tx_last is high. The CRC uses polynomial x^8+x^2+x+1 with initial value 0xFF. Bits are shifted in MSB-first (feedback = crc[7] xor bit) in the order beat 0..7, and within each beat the data bits 0..7 come first and then the flag bit as sent.
- R6: With CRC disabled, the burst is exactly eight beats and tx_last is high on beat 7.
- R7: A rd_start pulse arriving while tx_valid is high is ignored, and the burst in progress is not altered.
- R8: Each byte lane makes its own inversion decisions and computes its own CRC over only its own 72 wire bits.
- R9: With CRC enabled, a write burst is nine wr_valid beats. For each lane, the ninth beat's wr_dq byte is compared with the CRC (as in R5) over the first eight beats' wr_dq and wr_dbi_n bits as received. On a mismatch, that lane's crc_err bit is set in the cycle after the ninth beat.
- R10: A crc_err bit stays set until err_clr is high at a clock edge. If a mismatch and err_clr fall on the same edge, the bit ends up set.
- R11: With CRC disabled, write bursts are eight beats long and no check is made, so crc_err is left unchanged.
- R12: The inversion and CRC modes in force for a read burst are the values present at the accepted rd_start edge; changing them during the burst has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbi_en | input | 1 | Enable per-beat inversion on reads |
| crc_en | input | 1 | Enable CRC beat on reads and CRC check on writes |
| rd_start | input | 1 | Launch a read burst from rd_data |
| rd_data | input | LANES*64 | Eight bytes per lane, lane-major, beat 0 lowest |
| tx_valid | output | 1 | A read beat is on tx_dq/tx_dbi_n |
| tx_last | output | 1 | Final beat of the read burst |
| tx_dq | output | LANES*8 | Read data lines, one byte per lane |
| tx_dbi_n | output | LANES | Inversion flag per lane, low when inverted |
| wr_valid | input | 1 | A write beat is on wr_dq/wr_dbi_n |
| wr_dq | input | LANES*8 | Received write data lines |
| wr_dbi_n | input | LANES | Received flag line per lane |
| err_clr | input | 1 | Clear all latched CRC errors |
| crc_err | output | LANES | Sticky write CRC mismatch per lane |

## Verification
The main same-cycle collision is the write check's error update meeting err_clr. The bench asserts the clear on the exact edge that captures a corrupted ninth beat and expects the flag to be set afterwards; it then clears separately and expects the flag to drop. A second overlap is a new rd_start landing in the middle of a burst, together with flipped mode inputs. Here the bench demands that every remaining beat match the frame computed from the original data and modes, and that the line goes idle right after.

// File: rtl/dbi_crc_pkg.sv
package dbi_crc_pkg;
    localparam int BEATS    = 8;
    localparam int BYTE_W   = 8;
    localparam int CRC_W    = 8;
    localparam int LANE_BITS = BEATS * BYTE_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam logic [CRC_W-1:0] CRC_INIT = 8'hFF;
    localparam int INV_LIMIT = 4;

    function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic b);
        logic [CRC_W-1:0] sh;
        sh = {c[CRC_W-2:0], 1'b0};
        return (c[CRC_W-1] ^ b) ? (sh ^ CRC_POLY) : sh;
    endfunction

    function automatic logic [CRC_W-1:0] crc_beat(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] dq,
                                                  input logic flag);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) r = crc_bit(r, dq[i]);
        return crc_bit(r, flag);
    endfunction

    function automatic logic [3:0] zero_count(input logic [BYTE_W-1:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < BYTE_W; i++) n = n + {3'd0, ~v[i]};
        return n;
    endfunction
endpackage

// File: rtl/lane_dbi_crc_enc.sv
module lane_dbi_crc_enc
    import dbi_crc_pkg::*;
(
    input  logic [LANE_BITS-1:0] raw,
    input  logic                 dbi_en,
    output logic [LANE_BITS-1:0] wire_dq,
    output logic [BEATS-1:0]     wire_dbi_n,
    output logic [CRC_W-1:0]     crc
);
    logic [CRC_W-1:0]  acc;
    logic [BYTE_W-1:0] src;
    logic              inv;

    always_comb begin
        acc        = CRC_INIT;
        wire_dq    = '0;
        wire_dbi_n = '1;
        src        = '0;
        inv        = 1'b0;
        for (int b = 0; b < BEATS; b++) begin
            src = raw[b*BYTE_W +: BYTE_W];
            inv = dbi_en && (zero_count(src) > 4'(INV_LIMIT));
            wire_dq[b*BYTE_W +: BYTE_W] = inv ? ~src : src;
            wire_dbi_n[b] = ~inv;
            acc = crc_beat(acc, wire_dq[b*BYTE_W +: BYTE_W], ~inv);
        end
        crc = acc;
    end
endmodule

// File: rtl/lane_wr_crc_step.sv
module lane_wr_crc_step
    import dbi_crc_pkg::*;
(
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] dq,
    input  logic              flag,
    output logic [CRC_W-1:0]  crc_next,
    output logic              mismatch
);
    always_comb begin
        crc_next = crc_beat(crc_in, dq, flag);
        mismatch = (dq != crc_in);
    end
endmodule

// File: rtl/rd_dbi_crc_framer.sv
module rd_dbi_crc_framer
    import dbi_crc_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dbi_en,
    input  logic                       crc_en,
    input  logic                       rd_start,
    input  logic [LANES*LANE_BITS-1:0] rd_data,
    output logic                       tx_valid,
    output logic                       tx_last,
    output logic [LANES*BYTE_W-1:0]    tx_dq,
    output logic [LANES-1:0]           tx_dbi_n,
    input  logic                       wr_valid,
    input  logic [LANES*BYTE_W-1:0]    wr_dq,
    input  logic [LANES-1:0]           wr_dbi_n,
    input  logic                       err_clr,
    output logic [LANES-1:0]           crc_err
);
    localparam int SLOTS    = BEATS + 1;
    localparam int SLOT_DQ  = LANES * BYTE_W;
    localparam int FRM_DQ_W = SLOTS * SLOT_DQ;
    localparam int FRM_FL_W = SLOTS * LANES;
    localparam logic [3:0] LAST_CRC   = 4'(BEATS);
    localparam logic [3:0] LAST_PLAIN = 4'(BEATS - 1);

    typedef struct packed {
        logic                     busy;
        logic [3:0]               slot;
        logic [3:0]               last;
        logic [FRM_DQ_W-1:0]      frm_dq;
        logic [FRM_FL_W-1:0]      frm_fl;
        logic [3:0]               wcnt;
        logic [LANES*CRC_W-1:0]   wcrc;
        logic [LANES-1:0]         err;
    } state_t;

    state_t st_d, st_q;

    logic [LANES*LANE_BITS-1:0] enc_dq;
    logic [LANES*BEATS-1:0]     enc_fl;
    logic [LANES*CRC_W-1:0]     enc_crc;
    logic [LANES*CRC_W-1:0]     wstep;
    logic [LANES-1:0]           wmis;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_dbi_crc_enc u_enc (
            .raw        (rd_data[l*LANE_BITS +: LANE_BITS]),
            .dbi_en     (dbi_en),
            .wire_dq    (enc_dq[l*LANE_BITS +: LANE_BITS]),
            .wire_dbi_n (enc_fl[l*BEATS +: BEATS]),
            .crc        (enc_crc[l*CRC_W +: CRC_W])
        );
        lane_wr_crc_step u_wstep (
            .crc_in   (st_q.wcrc[l*CRC_W +: CRC_W]),
            .dq       (wr_dq[l*BYTE_W +: BYTE_W]),
            .flag     (wr_dbi_n[l]),
            .crc_next (wstep[l*CRC_W +: CRC_W]),
            .mismatch (wmis[l])
        );
    end

    always_comb begin
        st_d = st_q;
        // read burst sequencing
        if (!st_q.busy) begin
            if (rd_start) begin
                st_d.busy = 1'b1;
                st_d.slot = '0;
                st_d.last = crc_en ? LAST_CRC : LAST_PLAIN;
                for (int s = 0; s < BEATS; s++) begin
                    for (int l = 0; l < LANES; l++) begin
                        st_d.frm_dq[(s*LANES+l)*BYTE_W +: BYTE_W] =
                            enc_dq[l*LANE_BITS + s*BYTE_W +: BYTE_W];
                        st_d.frm_fl[s*LANES+l] = enc_fl[l*BEATS + s];
                    end
                end
                for (int l = 0; l < LANES; l++) begin
                    st_d.frm_dq[(BEATS*LANES+l)*BYTE_W +: BYTE_W] =
                        crc_en ? enc_crc[l*CRC_W +: CRC_W] : '0;
                    st_d.frm_fl[BEATS*LANES+l] = 1'b1;
                end
            end
        end else begin
            st_d.frm_dq = st_q.frm_dq >> SLOT_DQ;
            st_d.frm_fl = {{LANES{1'b1}}, st_q.frm_fl[FRM_FL_W-1:LANES]};
            if (st_q.slot == st_q.last) st_d.busy = 1'b0;
            else                        st_d.slot = st_q.slot + 4'd1;
        end
        // write check; a detected mismatch overrides a same-edge clear
        if (err_clr) st_d.err = '0;
        if (wr_valid) begin
            if (st_q.wcnt == LAST_CRC) begin
                st_d.err  = st_d.err | wmis;
                st_d.wcnt = '0;
                st_d.wcrc = {LANES{CRC_INIT}};
            end else if (!crc_en && st_q.wcnt == LAST_PLAIN) begin
                st_d.wcnt = '0;
                st_d.wcrc = {LANES{CRC_INIT}};
            end else begin
                st_d.wcnt = st_q.wcnt + 4'd1;
                st_d.wcrc = wstep;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy   <= 1'b0;
            st_q.slot   <= '0;
            st_q.last   <= '0;
            st_q.frm_dq <= '0;
            st_q.frm_fl <= '1;
            st_q.wcnt   <= '0;
            st_q.wcrc   <= {LANES{CRC_INIT}};
            st_q.err    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.busy;
    assign tx_last  = st_q.busy && (st_q.slot == st_q.last);
    assign tx_dq    = st_q.frm_dq[SLOT_DQ-1:0];
    assign tx_dbi_n = st_q.frm_fl[LANES-1:0];
    assign crc_err  = st_q.err;
endmodule

// File: rtl/rd_dbi_crc_framer_chk.sv
module rd_dbi_crc_framer_chk #(
    parameter int LANES = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_start,
    input logic               tx_valid,
    input logic               tx_last,
    input logic [LANES*8-1:0] tx_dq,
    input logic [LANES-1:0]   tx_dbi_n,
    input logic               wr_valid,
    input logic               err_clr,
    input logic [LANES-1:0]   crc_err
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> (tx_dq == '0 && tx_dbi_n == '1));

    assert_last_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last) |=> tx_valid);

    assert_start_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(rd_start));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        assert_inv_heavy_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid && !tx_dbi_n[l]) |-> ($countones(tx_dq[l*8 +: 8]) > 4));

        assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (crc_err[l] && !err_clr) |=> crc_err[l]);

        assert_err_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(crc_err[l]) |-> $past(wr_valid));
    end
endmodule

bind rd_dbi_crc_framer rd_dbi_crc_framer_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_start (rd_start),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .tx_dq    (tx_dq),
    .tx_dbi_n (tx_dbi_n),
    .wr_valid (wr_valid),
    .err_clr  (err_clr),
    .crc_err  (crc_err)
);

// File: tb/rd_dbi_crc_framer_tb.sv
module rd_dbi_crc_framer_tb;
    localparam int LANES = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst_n, dbi_en, crc_en, rd_start, wr_valid, err_clr;
    logic [LANES*64-1:0]  rd_data;
    logic                 tx_valid, tx_last;
    logic [LANES*8-1:0]   tx_dq, wr_dq;
    logic [LANES-1:0]     tx_dbi_n, wr_dbi_n, crc_err;

    rd_dbi_crc_framer #(.LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .dbi_en(dbi_en), .crc_en(crc_en),
        .rd_start(rd_start), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_dq(tx_dq), .tx_dbi_n(tx_dbi_n),
        .wr_valid(wr_valid), .wr_dq(wr_dq), .wr_dbi_n(wr_dbi_n),
        .err_clr(err_clr), .crc_err(crc_err)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    logic [7:0]       e_dq  [0:8][0:LANES-1];
    logic             e_fl  [0:8][0:LANES-1];
    logic [LANES-1:0] exp_err = '0;

    function automatic logic [7:0] m_step(input logic [7:0] c, input logic b);
        if (c[7] ^ b) return {c[6:0], 1'b0} ^ 8'h07;
        return {c[6:0], 1'b0};
    endfunction

    function automatic logic [7:0] m_crc(input logic [63:0] dq, input logic [7:0] fl);
        logic [7:0] c;
        c = 8'hFF;
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < 8; i++) c = m_step(c, dq[b*8+i]);
            c = m_step(c, fl[b]);
        end
        return c;
    endfunction

    task automatic build(input logic [LANES*64-1:0] raw, input logic dbi);
        for (int l = 0; l < LANES; l++) begin
            logic [63:0] wq;
            logic [7:0]  wf;
            for (int b = 0; b < 8; b++) begin
                logic [7:0] by;
                int z;
                by = raw[l*64 + b*8 +: 8];
                z  = 0;
                for (int i = 0; i < 8; i++) if (!by[i]) z++;
                wq[b*8 +: 8] = (dbi && z > 4) ? ~by : by;
                wf[b]        = !(dbi && z > 4);
                e_dq[b][l]   = wq[b*8 +: 8];
                e_fl[b][l]   = wf[b];
            end
            e_dq[8][l] = m_crc(wq, wf);
            e_fl[8][l] = 1'b1;
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_frame(input logic [LANES*64-1:0] raw, input logic dbi, input logic crc,
                              input string req, input bit poke, input logic [LANES*64-1:0] raw2);
        int n;
        build(raw, dbi);
        n = crc ? 9 : 8;
        @(negedge clk);
        rd_data = raw; dbi_en = dbi; crc_en = crc; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        for (int b = 0; b < n; b++) begin
            for (int l = 0; l < LANES; l++)
                chk(tx_valid && tx_dq[l*8 +: 8] == e_dq[b][l] && tx_dbi_n[l] == e_fl[b][l], req,
                    {22'd0, tx_valid, tx_dbi_n[l], tx_dq[l*8 +: 8]},
                    {22'd0, 1'b1, e_fl[b][l], e_dq[b][l]});
            chk(tx_last == (b == n - 1), crc ? "R5 last" : "R6 last", {31'd0, tx_last},
                {31'd0, b == n - 1});
            if (poke && b == 1) begin
                rd_start = 1'b1; rd_data = raw2; dbi_en = ~dbi; crc_en = ~crc;
            end
            @(negedge clk);
            rd_start = 1'b0;
        end
        chk(!tx_valid && tx_dq == '0 && tx_dbi_n == '1, "R1 idle after burst",
            {15'd0, tx_valid, tx_dbi_n, 6'd0, tx_dq}, {16'd0, 2'b11, 14'd0});
    endtask

    task automatic write_frame(input logic [LANES*64-1:0] wq, input logic [LANES*8-1:0] wf,
                               input logic [LANES-1:0] bad, input logic crc, input bit clr_last);
        int n;
        n = crc ? 9 : 8;
        crc_en = crc;
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            err_clr  = clr_last && (b == n - 1);
            for (int l = 0; l < LANES; l++) begin
                if (b < 8) begin
                    wr_dq[l*8 +: 8] = wq[l*64 + b*8 +: 8];
                    wr_dbi_n[l]     = wf[l*8 + b];
                end else begin
                    wr_dq[l*8 +: 8] = m_crc(wq[l*64 +: 64], wf[l*8 +: 8]) ^ {7'd0, bad[l]};
                    wr_dbi_n[l]     = 1'b1;
                end
            end
        end
        @(negedge clk);
        wr_valid = 1'b0; err_clr = 1'b0;
        if (clr_last) exp_err = '0;
        if (crc) exp_err = exp_err | bad;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [LANES*64-1:0] r, r2;
        logic [LANES*8-1:0]  f;
        logic [LANES-1:0]    bad;
        void'($urandom(32'h5EED));
        rst_n = 1'b0; dbi_en = 0; crc_en = 0; rd_start = 0; rd_data = '0;
        wr_valid = 0; wr_dq = '0; wr_dbi_n = '1; err_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!tx_valid && !tx_last && tx_dq == '0 && tx_dbi_n == '1 && crc_err == '0, "R1 reset",
            {14'd0, tx_valid, tx_last, tx_dbi_n, crc_err, tx_dq}, {16'd0, 2'b11, 2'b00, 16'd0});
        rst_n = 1'b1;

        // R2 boundary: 0x0F has 4 zeros, 0x07 has 5, plus extremes; R8 lanes differ
        read_frame({64'h0F07_00FF_EF10_F00E, 64'h0102_0408_1F3F_7FFE}, 1, 1, "R2 R5 R8 directed", 0, '0);
        // R3 inversion disabled with all-zero bytes
        read_frame({64'h0000_0000_0000_0000, 64'h0100_0000_0300_0000}, 0, 1, "R3 dbi off", 0, '0);
        // R6 eight-beat burst
        read_frame({64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF}, 1, 0, "R6 R4 crc off", 0, '0);
        // R7 and R12: restart and mode flip during a burst are ignored
        read_frame({64'h1234_5678_9ABC_DEF0, 64'h0F1E_2D3C_4B5A_6978}, 1, 1, "R7 R12 busy restart", 1,
                   {LANES{64'hFFFF_FFFF_FFFF_FFFF}});
        for (int k = 0; k < 30; k++) begin
            r = {$urandom, $urandom, $urandom, $urandom};
            read_frame(r, 1'($urandom), 1'($urandom), "R4 R2 random", 0, '0);
        end

        // R9 good frame then lane 1 corrupted
        r = {$urandom, $urandom, $urandom, $urandom}; f = 16'($urandom);
        write_frame(r, f, 2'b00, 1, 0);
        chk(crc_err == exp_err, "R9 good write", {30'd0, crc_err}, {30'd0, exp_err});
        write_frame(r, f, 2'b10, 1, 0);
        chk(crc_err == 2'b10, "R9 R8 lane1 mismatch", {30'd0, crc_err}, 32'd2);
        // R10 sticky across a clean frame
        write_frame(~r, ~f, 2'b00, 1, 0);
        chk(crc_err == 2'b10, "R10 sticky", {30'd0, crc_err}, 32'd2);
        // R11 crc off: garbage frame of 8 beats leaves flags alone
        write_frame(r, f, 2'b11, 0, 0);
        chk(crc_err == 2'b10, "R11 no check", {30'd0, crc_err}, 32'd2);
        // R10 clear alone
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; exp_err = '0;
        chk(crc_err == 2'b00, "R10 clear", {30'd0, crc_err}, 32'd0);
        // R10 clear meeting a mismatch on lane 0
        write_frame(r, f, 2'b01, 1, 1);
        chk(crc_err == 2'b01, "R10 set beats clear", {30'd0, crc_err}, 32'd1);
        // R9 R11 alignment after crc-off frame: next crc frame clean after clear
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; exp_err = '0;
        for (int k = 0; k < 20; k++) begin
            r   = {$urandom, $urandom, $urandom, $urandom};
            f   = 16'($urandom);
            bad = 2'($urandom);
            write_frame(r, f, bad, 1'($urandom), 0);
            chk(crc_err == exp_err, "R9 R11 random write", {30'd0, crc_err}, {30'd0, exp_err});
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule